// File: doc/BRIEF.md
# Accumulator Data-Movement Execution Unit

This unit carries out the data-movement operations of a small 8-bit accumulator machine once an upstream decoder has resolved the operation and the effective address. It owns the architectural state those operations touch. That state is two byte accumulators A and B, which pair into a 16-bit accumulator D with A as the upper byte. It also holds two 16-bit index registers X and Y, a 16-bit stack pointer and a condition-code byte.

The unit accepts an operation code, an effective address and a start strobe. It runs the operation and raises `done_o` for exactly one cycle once every result is visible. The operations are: clear, load, store, push, pull, register transfer and exchange of D with X or Y. Memory traffic goes through one synchronous byte port, and read data returns one cycle after its address. The stack pointer always addresses the next free byte, and the stack grows toward lower addresses.

Top module: `dmov_unit`

## Requirements
- R1: After reset, A, B, X, Y and the condition-code byte are zero, the stack pointer equals parameter SP_INIT (default 0x00FF), and `done_o` and `mem_we_o` are low. Condition-code bits are C=bit0, V=bit1, Z=bit2, N=bit3.
- R2: Clear (op 0 = A, op 1 = B, op 2 = memory byte at `ea_i`) writes zero to its target, sets Z, clears N, V and C, and leaves all other state untouched.
- R3: Load (op 3 = A, op 4 = B, op 5 = D) reads the operand at `ea_i`. For D, the byte at `ea_i` goes to A and the byte at `ea_i`+1 goes to B. N is the top bit of the loaded width, Z is set only when every bit of that width is zero, V is cleared and C is kept.
- R4: Store (op 6 = A, op 7 = B, op 8 = D) writes the operand to `ea_i`, with D stored as A at `ea_i` and B at `ea_i`+1. N and Z come from the stored value, V is cleared and C is kept.
- R5: Push (op 9 = A, op 10 = B) writes the byte at the stack-pointer address, then decrements the stack pointer.
- R6: Pull (op 11 = A, op 12 = B) first increments the stack pointer, then loads the byte at the new address. Push and pull leave the condition-code byte unchanged.
- R7: Transfers: op 13 copies A to B and op 14 copies B to A, both setting N and Z from the byte and clearing V with C kept. Op 15 copies A into the whole condition-code byte. Op 16 copies the condition-code byte into A without changing any flag.
- R8: Op 17 swaps D with X and op 18 swaps D with Y, both in one update, with no flag change.
- R9: `done_o` is high for exactly one cycle per accepted operation. Counting clock edges from the edge that samples `start_i`, it rises after 1 edge for register operations, 2 for byte store, clear of memory and push, 3 for byte load, pull and 16-bit store, and 5 for 16-bit load.
- R10: Read data is consumed one cycle after its address is presented. `mem_we_o` is high only in a write cycle, with `mem_addr_o` and `mem_wdata_o` holding the target byte.
- R11: An operation code of 19 or above completes after one edge and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when idle |
| op_i | input | 5 | Operation code |
| ea_i | input | AW | Effective address |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | AW | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after address |
| acc_a_o | output | DW | Accumulator A |
| acc_b_o | output | DW | Accumulator B |
| idx_x_o | output | 2*DW | Index register X |
| idx_y_o | output | 2*DW | Index register Y |
| sp_o | output | AW | Stack pointer |
| ccr_o | output | DW | Condition-code byte |

## Verification
The hardest states to reach are the ones where the carry and overflow flags are set. No data-movement operation sets them itself, so the only way in is the A-to-condition-code transfer. The stimulus therefore loads a chosen byte into A and moves it into the flags. The loads, transfers, pulls and stores that follow can then show that V is cleared, that C survives, and that pull leaves N untouched. X and Y have no direct load, so they are written by swapping a prepared D into them and swapping back. A 16-bit store followed by a 16-bit load from the same address confirms the byte order.

// File: rtl/dmov_pkg.sv
package dmov_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_CLR_A   = 5'd0,
    OP_CLR_B   = 5'd1,
    OP_CLR_M   = 5'd2,
    OP_LD_A    = 5'd3,
    OP_LD_B    = 5'd4,
    OP_LD_D    = 5'd5,
    OP_ST_A    = 5'd6,
    OP_ST_B    = 5'd7,
    OP_ST_D    = 5'd8,
    OP_PSH_A   = 5'd9,
    OP_PSH_B   = 5'd10,
    OP_PUL_A   = 5'd11,
    OP_PUL_B   = 5'd12,
    OP_MOV_AB  = 5'd13,
    OP_MOV_BA  = 5'd14,
    OP_MOV_AC  = 5'd15,
    OP_MOV_CA  = 5'd16,
    OP_SWAP_DX = 5'd17,
    OP_SWAP_DY = 5'd18
  } op_e;

  typedef enum logic [1:0] {K_REG, K_READ, K_WRITE} kind_e;

  // flag nibble layout: {N, Z, V, C}
  function automatic logic [3:0] nz_flags(input logic [3:0] f, input logic n, input logic z);
    return {n, z, 1'b0, f[0]};
  endfunction

  function automatic logic [3:0] clr_flags();
    return 4'b0100;
  endfunction

endpackage

// File: rtl/dmov_flags.sv
module dmov_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  output logic         neg_o,
  output logic         zero_o
);
  assign neg_o  = val_i[W-1];
  assign zero_o = (val_i == '0);
endmodule

// File: rtl/dmov_ctrl.sv
module dmov_ctrl
  import dmov_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  kind_e         kind_i,
  input  logic          wide_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [DW-1:0] wr_hi_i,
  input  logic [DW-1:0] wr_lo_i,
  output logic          busy_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          rd_hi_o,
  output logic          rd_lo_o,
  output logic          wr_last_o
);
  typedef enum logic [1:0] {S_IDLE, S_RADDR, S_RDATA, S_WRITE} st_e;

  st_e           state_q;
  logic [AW-1:0] addr_q;
  logic          wide_q, first_q;
  logic          more;

  assign more = wide_q && first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (go_i && kind_i != K_REG) begin
          addr_q  <= base_addr_i;
          wide_q  <= wide_i;
          first_q <= 1'b1;
          state_q <= (kind_i == K_READ) ? S_RADDR : S_WRITE;
        end
        S_RADDR: state_q <= S_RDATA;
        S_RDATA: begin
          if (more) begin
            first_q <= 1'b0;
            addr_q  <= addr_q + 1'b1;
            state_q <= S_RADDR;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (more) begin
            first_q <= 1'b0;
            addr_q  <= addr_q + 1'b1;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign mem_addr_o  = addr_q;
  assign mem_we_o    = (state_q == S_WRITE);
  assign mem_wdata_o = more ? wr_hi_i : wr_lo_i;
  assign rd_hi_o     = (state_q == S_RDATA) && more;
  assign rd_lo_o     = (state_q == S_RDATA) && !more;
  assign wr_last_o   = (state_q == S_WRITE) && !more;
endmodule

// File: rtl/dmov_unit.sv
module dmov_unit
  import dmov_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          AW      = 16,
  parameter logic [15:0] SP_INIT = 16'h00FF,
  localparam int         WW      = 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [AW-1:0]   ea_i,
  output logic            done_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   acc_a_o,
  output logic [DW-1:0]   acc_b_o,
  output logic [WW-1:0]   idx_x_o,
  output logic [WW-1:0]   idx_y_o,
  output logic [AW-1:0]   sp_o,
  output logic [DW-1:0]   ccr_o
);
  logic [DW-1:0] a_q, b_q, ccr_q;
  logic [WW-1:0] x_q, y_q;
  logic [AW-1:0] sp_q;
  op_e           op_q, op_in;
  logic          done_q;

  logic          busy, accept, rd_hi, rd_lo, wr_last;
  kind_e         kind;
  logic          wide;
  logic [AW-1:0] base;
  logic [DW-1:0] wr_lo, byte_val;
  logic [WW-1:0] word_val;
  logic          n_b, z_b, n_w, z_w;

  assign op_in  = op_e'(op_i);
  assign accept = start_i && !busy;

  always_comb begin
    kind = K_REG;
    wide = 1'b0;
    base = ea_i;
    case (op_in)
      OP_LD_A, OP_LD_B:            kind = K_READ;
      OP_LD_D:                     begin kind = K_READ;  wide = 1'b1; end
      OP_ST_A, OP_ST_B, OP_CLR_M:  kind = K_WRITE;
      OP_ST_D:                     begin kind = K_WRITE; wide = 1'b1; end
      OP_PSH_A, OP_PSH_B:          begin kind = K_WRITE; base = sp_q; end
      OP_PUL_A, OP_PUL_B:          begin kind = K_READ;  base = sp_q + 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_ST_B, OP_PSH_B, OP_ST_D: wr_lo = b_q;
      OP_CLR_M:                   wr_lo = '0;
      default:                    wr_lo = a_q;
    endcase
  end

  // flag source: read byte, stored byte, or transferred byte
  always_comb begin
    if (rd_lo)     byte_val = mem_rdata_i;
    else if (busy) byte_val = (op_q == OP_ST_B) ? b_q : a_q;
    else           byte_val = (op_in == OP_MOV_BA) ? b_q : a_q;
    word_val = rd_lo ? {a_q, mem_rdata_i} : {a_q, b_q};
  end

  dmov_flags #(.W(DW)) u_flg_b (.val_i(byte_val), .neg_o(n_b), .zero_o(z_b));
  dmov_flags #(.W(WW)) u_flg_w (.val_i(word_val), .neg_o(n_w), .zero_o(z_w));

  dmov_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (accept),
    .kind_i      (kind),
    .wide_i      (wide),
    .base_addr_i (base),
    .wr_hi_i     (a_q),
    .wr_lo_i     (wr_lo),
    .busy_o      (busy),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .rd_hi_o     (rd_hi),
    .rd_lo_o     (rd_lo),
    .wr_last_o   (wr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      ccr_q  <= '0;
      sp_q   <= AW'(SP_INIT);
      op_q   <= OP_CLR_A;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q   <= op_in;
        done_q <= (kind == K_REG);
        case (op_in)
          OP_CLR_A:   begin a_q <= '0; ccr_q[3:0] <= clr_flags(); end
          OP_CLR_B:   begin b_q <= '0; ccr_q[3:0] <= clr_flags(); end
          OP_MOV_AB:  begin b_q <= a_q; ccr_q[3:0] <= nz_flags(ccr_q[3:0], n_b, z_b); end
          OP_MOV_BA:  begin a_q <= b_q; ccr_q[3:0] <= nz_flags(ccr_q[3:0], n_b, z_b); end
          OP_MOV_AC:  ccr_q <= a_q;
          OP_MOV_CA:  a_q <= ccr_q;
          OP_SWAP_DX: begin {a_q, b_q} <= x_q; x_q <= {a_q, b_q}; end
          OP_SWAP_DY: begin {a_q, b_q} <= y_q; y_q <= {a_q, b_q}; end
          OP_PUL_A, OP_PUL_B: sp_q <= sp_q + 1'b1;
          default: ;
        endcase
      end
      if (rd_hi) a_q <= mem_rdata_i;
      if (rd_lo) begin
        done_q <= 1'b1;
        case (op_q)
          OP_LD_A:  begin a_q <= mem_rdata_i; ccr_q[3:0] <= nz_flags(ccr_q[3:0], n_b, z_b); end
          OP_LD_B:  begin b_q <= mem_rdata_i; ccr_q[3:0] <= nz_flags(ccr_q[3:0], n_b, z_b); end
          OP_LD_D:  begin b_q <= mem_rdata_i; ccr_q[3:0] <= nz_flags(ccr_q[3:0], n_w, z_w); end
          OP_PUL_A: a_q <= mem_rdata_i;
          OP_PUL_B: b_q <= mem_rdata_i;
          default: ;
        endcase
      end
      if (wr_last) begin
        done_q <= 1'b1;
        case (op_q)
          OP_ST_A, OP_ST_B:   ccr_q[3:0] <= nz_flags(ccr_q[3:0], n_b, z_b);
          OP_ST_D:            ccr_q[3:0] <= nz_flags(ccr_q[3:0], n_w, z_w);
          OP_CLR_M:           ccr_q[3:0] <= clr_flags();
          OP_PSH_A, OP_PSH_B: sp_q <= sp_q - 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign acc_a_o = a_q;
  assign acc_b_o = b_q;
  assign idx_x_o = x_q;
  assign idx_y_o = y_q;
  assign sp_o    = sp_q;
  assign ccr_o   = ccr_q;
endmodule

// File: rtl/dmov_unit_chk.sv
module dmov_unit_chk
  import dmov_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [OP_W-1:0] op_i,
  input logic            done_o,
  input logic            mem_we_o,
  input logic [DW-1:0]   acc_a_o,
  input logic [DW-1:0]   acc_b_o,
  input logic [2*DW-1:0] idx_x_o,
  input logic [AW-1:0]   sp_o,
  input logic [DW-1:0]   ccr_o,
  input logic            busy_i,
  input logic [OP_W-1:0] op_q_i
);
  logic acc;
  logic stack_op;
  assign acc      = start_i && !busy_i;
  assign stack_op = (op_q_i == OP_PSH_A) || (op_q_i == OP_PSH_B) ||
                    (op_q_i == OP_PUL_A) || (op_q_i == OP_PUL_B);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_we_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_i);

  assert_clear_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == OP_CLR_A) |=> (acc_a_o == '0 && ccr_o[3:0] == 4'b0100));

  assert_push_sp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q_i == OP_PSH_A || op_q_i == OP_PSH_B)) |-> sp_o == $past(sp_o) - 1'b1);

  assert_pull_sp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (op_i == OP_PUL_A || op_i == OP_PUL_B)) |=> sp_o == $past(sp_o) + 1'b1);

  assert_stack_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && stack_op) |=> $stable(ccr_o));

  assert_swap_dx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op_i == OP_SWAP_DX) |=>
      (idx_x_o == $past({acc_a_o, acc_b_o}) && {acc_a_o, acc_b_o} == $past(idx_x_o)));
endmodule

bind dmov_unit dmov_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .done_o   (done_o),
  .mem_we_o (mem_we_o),
  .acc_a_o  (acc_a_o),
  .acc_b_o  (acc_b_o),
  .idx_x_o  (idx_x_o),
  .sp_o     (sp_o),
  .ccr_o    (ccr_o),
  .busy_i   (busy),
  .op_q_i   (op_q)
);

// File: tb/dmov_unit_test.sv
`timescale 1ns/1ps
module dmov_unit_test;
  import dmov_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [15:0] ea_i = '0;
  logic        done_o, mem_we_o;
  logic [15:0] mem_addr_o, idx_x_o, idx_y_o, sp_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i, acc_a_o, acc_b_o, ccr_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk_i = ~clk_i;

  dmov_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .ea_i(ea_i),
    .done_o(done_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .idx_x_o(idx_x_o), .idx_y_o(idx_y_o),
    .sp_o(sp_o), .ccr_o(ccr_o)
  );

  logic [7:0] mem [256];
  always @(posedge clk_i) begin
    if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o[7:0]];
  end

  typedef struct packed {
    logic [4:0]  op;
    logic [7:0]  ea;
    logic [7:0]  a, b, f;
    logic [15:0] x, y;
    logic [7:0]  sp;
    logic [3:0]  lat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{OP_LD_A,    8'h40, 8'h0F, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hFF, 4'd3, 4'd3},  // R3
    '{OP_MOV_AC,  8'h00, 8'h0F, 8'h00, 8'h0F, 16'h0000, 16'h0000, 8'hFF, 4'd1, 4'd7},  // R7 sets V and C
    '{OP_LD_B,    8'h41, 8'h0F, 8'h80, 8'h09, 16'h0000, 16'h0000, 8'hFF, 4'd3, 4'd3},  // R3 V cleared, C kept
    '{OP_MOV_BA,  8'h00, 8'h80, 8'h80, 8'h09, 16'h0000, 16'h0000, 8'hFF, 4'd1, 4'd7},  // R7
    '{OP_PSH_A,   8'h00, 8'h80, 8'h80, 8'h09, 16'h0000, 16'h0000, 8'hFE, 4'd2, 4'd5},  // R5
    '{OP_CLR_A,   8'h00, 8'h00, 8'h80, 8'h04, 16'h0000, 16'h0000, 8'hFE, 4'd1, 4'd2},  // R2
    '{OP_PUL_A,   8'h00, 8'h80, 8'h80, 8'h04, 16'h0000, 16'h0000, 8'hFF, 4'd3, 4'd6},  // R6 flags kept
    '{OP_LD_D,    8'h10, 8'h00, 8'h01, 8'h00, 16'h0000, 16'h0000, 8'hFF, 4'd5, 4'd3},  // R3 Z over 16 bits
    '{OP_LD_D,    8'h20, 8'h00, 8'h00, 8'h04, 16'h0000, 16'h0000, 8'hFF, 4'd5, 4'd3},  // R3
    '{OP_LD_D,    8'h12, 8'h80, 8'h00, 8'h08, 16'h0000, 16'h0000, 8'hFF, 4'd5, 4'd3},  // R3 N from bit 15
    '{OP_SWAP_DX, 8'h00, 8'h00, 8'h00, 8'h08, 16'h8000, 16'h0000, 8'hFF, 4'd1, 4'd8},  // R8
    '{OP_ST_D,    8'h50, 8'h00, 8'h00, 8'h04, 16'h8000, 16'h0000, 8'hFF, 4'd3, 4'd4},  // R4
    '{OP_SWAP_DX, 8'h00, 8'h80, 8'h00, 8'h04, 16'h0000, 16'h0000, 8'hFF, 4'd1, 4'd8},  // R8
    '{OP_ST_D,    8'h52, 8'h80, 8'h00, 8'h08, 16'h0000, 16'h0000, 8'hFF, 4'd3, 4'd4},  // R4
    '{OP_CLR_A,   8'h00, 8'h00, 8'h00, 8'h04, 16'h0000, 16'h0000, 8'hFF, 4'd1, 4'd2},  // R2
    '{OP_LD_D,    8'h52, 8'h80, 8'h00, 8'h08, 16'h0000, 16'h0000, 8'hFF, 4'd5, 4'd3},  // R3 byte order
    '{OP_MOV_CA,  8'h00, 8'h08, 8'h00, 8'h08, 16'h0000, 16'h0000, 8'hFF, 4'd1, 4'd7},  // R7
    '{OP_ST_B,    8'h54, 8'h08, 8'h00, 8'h04, 16'h0000, 16'h0000, 8'hFF, 4'd2, 4'd4},  // R4
    '{OP_LD_B,    8'h30, 8'h08, 8'h7F, 8'h00, 16'h0000, 16'h0000, 8'hFF, 4'd3, 4'd3},  // R3
    '{OP_CLR_M,   8'h55, 8'h08, 8'h7F, 8'h04, 16'h0000, 16'h0000, 8'hFF, 4'd2, 4'd2},  // R2
    '{OP_LD_B,    8'h55, 8'h08, 8'h00, 8'h04, 16'h0000, 16'h0000, 8'hFF, 4'd3, 4'd2},  // R2 byte cleared
    '{OP_SWAP_DY, 8'h00, 8'h00, 8'h00, 8'h04, 16'h0000, 16'h0800, 8'hFF, 4'd1, 4'd8},  // R8
    '{OP_LD_A,    8'h41, 8'h80, 8'h00, 8'h08, 16'h0000, 16'h0800, 8'hFF, 4'd3, 4'd3},  // R3
    '{OP_CLR_B,   8'h00, 8'h80, 8'h00, 8'h04, 16'h0000, 16'h0800, 8'hFF, 4'd1, 4'd2},  // R2
    '{OP_ST_A,    8'h57, 8'h80, 8'h00, 8'h08, 16'h0000, 16'h0800, 8'hFF, 4'd2, 4'd4},  // R4
    '{OP_LD_B,    8'h57, 8'h80, 8'h80, 8'h08, 16'h0000, 16'h0800, 8'hFF, 4'd3, 4'd3},  // R3
    '{OP_LD_A,    8'h43, 8'h06, 8'h80, 8'h00, 16'h0000, 16'h0800, 8'hFF, 4'd3, 4'd3},  // R3
    '{OP_MOV_AC,  8'h00, 8'h06, 8'h80, 8'h06, 16'h0000, 16'h0800, 8'hFF, 4'd1, 4'd7},  // R7
    '{OP_MOV_AB,  8'h00, 8'h06, 8'h06, 8'h00, 16'h0000, 16'h0800, 8'hFF, 4'd1, 4'd7}   // R7 V cleared
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] op, input logic [15:0] ea, output int lat);
    @(negedge clk_i);
    op_i = op; ea_i = ea; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    mem[8'h10] = 8'h00; mem[8'h11] = 8'h01; mem[8'h12] = 8'h80; mem[8'h13] = 8'h00;
    mem[8'h20] = 8'h00; mem[8'h21] = 8'h00; mem[8'h30] = 8'h7F;
    mem[8'h40] = 8'h0F; mem[8'h41] = 8'h80; mem[8'h43] = 8'h06;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 a", acc_a_o, 0);
    chk("R1 b", acc_b_o, 0);
    chk("R1 ccr", ccr_o, 0);
    chk("R1 x", idx_x_o, 0);
    chk("R1 y", idx_y_o, 0);
    chk("R1 sp", sp_o, 16'h00FF);
    chk("R1 done", done_o, 0);
    chk("R1 we", mem_we_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      run_op(v.op, {8'h00, v.ea}, lat);
      tag = $sformatf("R%0d row%0d", v.req, i);
      chk({tag, " a"}, acc_a_o, v.a);
      chk({tag, " b"}, acc_b_o, v.b);
      chk({tag, " ccr"}, ccr_o, v.f);
      chk({tag, " x"}, idx_x_o, v.x);
      chk({tag, " y"}, idx_y_o, v.y);
      chk({tag, " sp"}, sp_o, {8'h00, v.sp});
      chk($sformatf("R9 latency row%0d", i), lat, v.lat);
      @(negedge clk_i);
      chk($sformatf("R9 single pulse row%0d", i), done_o, 0);
    end

    // memory side effects seen through the port
    chk("R5 pushed byte", mem[8'hFF], 8'h80);
    chk("R4 word hi", mem[8'h52], 8'h80);
    chk("R4 word lo", mem[8'h53], 8'h00);
    chk("R4 word zero", {mem[8'h50], mem[8'h51]}, 16'h0000);
    chk("R4 byte", mem[8'h57], 8'h80);
    chk("R2 mem clear", mem[8'h55], 8'h00);

    // R10 write cycle: address, data and enable in the cycle after start
    @(negedge clk_i);
    op_i = OP_ST_A; ea_i = 16'h0060; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 we", mem_we_o, 1);
    chk("R10 addr", mem_addr_o, 16'h0060);
    chk("R10 wdata", mem_wdata_o, 8'h06);
    @(negedge clk_i);
    chk("R10 we drop", mem_we_o, 0);

    // R10 read cycle: address out, no write
    @(negedge clk_i);
    op_i = OP_LD_B; ea_i = 16'h0060; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R10 rd addr", mem_addr_o, 16'h0060);
    chk("R10 rd we", mem_we_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R10 rd data", acc_b_o, 8'h06);

    // R11 undefined code
    run_op(5'd25, 16'h0000, lat);
    chk("R11 latency", lat, 1);
    chk("R11 a", acc_a_o, 8'h06);
    chk("R11 b", acc_b_o, 8'h06);
    chk("R11 ccr", ccr_o, 8'h00);
    chk("R11 sp", sp_o, 16'h00FF);
    chk("R11 y", idx_y_o, 16'h0800);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule